// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

This block is a single timer channel built around a 16-bit up-counter and four compare registers, numbered 0 to 3. Each compare register drives one output pin and one sticky match flag. A match occurs when the counter equals a register value in a cycle where the count enable is high. On a match, the pin applies a programmable 4-bit action: hold, drive low, drive high or toggle. A separate bit in the same field sets the pin's starting level.

The channel has two PWM modes. In paired mode, registers 0 and 1 together shape pin 0, and registers 2 and 3 together shape pin 2. In period/duty mode, one chosen register sets the period and restarts the counter, and every other register shapes its own pin. The compare values, the action fields, the mode and the clear source are all loaded through a simple write port. Turning the channel off, or changing its mode, returns the counter to zero and the pins to their starting levels.

Top module: `cmpwm_channel`

## Requirements
- R1: After reset all pins and flags read 0, the counter is 0, all compare values are 0, all action fields are 0 and the mode is paired.
- R2: While enabled, the counter advances by one on each cycle with `tick` high and holds otherwise. It returns to 0 on a match of the register chosen by mode bits [2:1]. In period/duty mode this clear always happens; in paired mode it happens only when mode bit 3 is set.
- R3: Each register has a flag that is set by its match. Writing address 6 with data bit i at 1 clears flag i. A match in the same cycle wins over the clear.
- R4: Action field bits [1:0] select the action on a match: 00 hold, 01 low, 10 high, 11 toggle. Bit 2 is the starting level. Bit 3 is stored as 0.
- R5: In paired mode (mode bit 0 = 0), matches of register 0 or 1 act on pin 0, each using its own field. Matches of register 2 or 3 act on pin 2 in the same way. Pins 1 and 3 stay low. The starting level of pin 0 is bit 2 of field 0, and that of pin 2 is bit 2 of field 2.
- R6: In paired mode, when both registers of a pair hold the same value, their match leaves the pin unchanged.
- R7: In period/duty mode (mode bit 0 = 1), the period match sets every pin to the starting level of its own field, and on the same edge the counter returns to 0.
- R8: In period/duty mode, the pin of the period register shows no PWM: it changes only when it is set to its starting level.
- R9: In period/duty mode, a duty register equal to the period register leaves its pin at its current level, even at the period match.
- R10: While `enable` is low, or on a write to address 5 that changes the mode value, the counter goes to 0 and each pin goes to the starting level of the new configuration.
- R11: The pin change and the flag set caused by a match are visible on the cycle after the counter equals the register value.
- R12: The write map is as follows. Addresses 0 to 3 load the compare values. Address 4 loads the action fields, with register i's field at data bits [4i+3:4i]. Address 5 loads the 4-bit mode. Address 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Channel run; low holds the channel in its restart state |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| pin_out | output | 4 | Output pin levels, one per compare register |
| match_flag | output | 4 | Sticky compare-match flags |

## Verification
The assertions assume that `rst_n` is held low for at least two clocks and that every write uses a defined address and data. They also assume that a mode write is the only way the mode changes, so a restart always follows a mode change on the same edge. The stimulus writes only on falling edges, and it draws addresses from 0 to 7 so that the unused address is exercised. Compare values are kept small and the clear enable is usually set, which keeps the counter cycling through the programmed matches well within the run.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;
  localparam int NCMP     = 4;
  localparam int ACT_W    = 4;
  localparam int ACT_BITS = NCMP * ACT_W;
  localparam int IDX_W    = $clog2(NCMP);
  localparam int MODE_W   = 4;
  localparam int M_CYC    = 0;   // 1: period/duty, 0: paired
  localparam int M_SEL_LO = 1;   // clear-source select [2:1]
  localparam int M_CLREN  = 3;   // paired-mode clear enable

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic [NCMP-1:0] start_levels(input logic cyc,
                                                   input logic [ACT_BITS-1:0] act);
    logic [NCMP-1:0] lv;
    for (int i = 0; i < NCMP; i++) begin
      if (cyc || (i % 2 == 0)) lv[i] = act[i*ACT_W+2];
      else                     lv[i] = 1'b0;
    end
    return lv;
  endfunction
endpackage

// File: rtl/cmpwm_rst_sync.sv
module cmpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/cmpwm_regs.sv
module cmpwm_regs
  import cmpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_sn,
  input  logic                         enable,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic [NCMP-1:0]              match,
  output logic [NCMP-1:0][CNT_W-1:0]   cmp_q,
  output logic [ACT_BITS-1:0]          act_q,
  output logic [ACT_BITS-1:0]          act_d,
  output logic [MODE_W-1:0]            mode_q,
  output logic [MODE_W-1:0]            mode_d,
  output logic                         restart,
  output logic [NCMP-1:0]              flag_q
);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(6);
  localparam logic [ACT_BITS-1:0] ACT_MASK = {NCMP{4'b0111}};

  logic [NCMP-1:0][CNT_W-1:0] cmp_d;
  logic [NCMP-1:0]            flag_d;
  logic [NCMP-1:0]            clr_mask;

  always_comb begin
    cmp_d    = cmp_q;
    act_d    = act_q;
    mode_d   = mode_q;
    clr_mask = '0;
    if (wr_en) begin
      if (wr_addr < ADDR_W'(NCMP)) cmp_d[wr_addr[IDX_W-1:0]] = wr_data;
      if (wr_addr == A_ACT)        act_d  = wr_data[ACT_BITS-1:0] & ACT_MASK;
      if (wr_addr == A_MODE)       mode_d = wr_data[MODE_W-1:0];
      if (wr_addr == A_FCLR)       clr_mask = wr_data[NCMP-1:0];
    end
    flag_d  = (flag_q & ~clr_mask) | match;
    restart = !enable || (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cmp_q  <= '0;
      act_q  <= '0;
      mode_q <= '0;
      flag_q <= '0;
    end else begin
      cmp_q  <= cmp_d;
      act_q  <= act_d;
      mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end

  // R3: a match always leaves its flag set on the next cycle
  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_sn)
    (|match) |=> ((flag_q & $past(match)) == $past(match)));

  // R4: reserved bit of every field stays clear
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |=> ((act_q & ~ACT_MASK) == '0));
endmodule

// File: rtl/cmpwm_counter.sv
module cmpwm_counter
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_sn,
  input  logic                       enable,
  input  logic                       tick,
  input  logic                       restart,
  input  logic                       cyc_mode,
  input  logic                       clr_en,
  input  logic [IDX_W-1:0]           sel,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_q,
  output logic [NCMP-1:0]            match
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;
  logic             clr_hit;

  assign step = enable && tick;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign match[g] = step && (cnt_q == cmp_q[g]);
  end

  always_comb begin
    clr_hit = match[sel] && (cyc_mode || clr_en);
    cnt_d   = cnt_q;
    if (restart)      cnt_d = '0;
    else if (step)    cnt_d = clr_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R10: restart leaves the counter at zero
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    restart |=> (cnt_q == '0));

  // R2: without a count enable the counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (!restart && !tick) |=> $stable(cnt_q));

  // R7: period match in period/duty mode returns counter to zero
  a_r7_period_clear: assert property (@(posedge clk) disable iff (!rst_sn)
    (cyc_mode && match[sel]) |=> (cnt_q == '0));
endmodule

// File: rtl/cmpwm_pins.sv
module cmpwm_pins
  import cmpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_sn,
  input  logic                       restart,
  input  logic [NCMP-1:0]            match,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_q,
  input  logic [ACT_BITS-1:0]        act_q,
  input  logic [ACT_BITS-1:0]        act_d,
  input  logic [MODE_W-1:0]          mode_q,
  input  logic [MODE_W-1:0]          mode_d,
  output logic [NCMP-1:0]            pin_q
);
  logic [NCMP-1:0]  pin_d;
  logic [NCMP-1:0]  init_q;
  logic [NCMP-1:0]  init_d;
  logic             cyc;
  logic [IDX_W-1:0] sel;

  assign cyc    = mode_q[M_CYC];
  assign sel    = mode_q[M_SEL_LO +: IDX_W];
  assign init_q = start_levels(cyc, act_q);
  assign init_d = start_levels(mode_d[M_CYC], act_d);

  always_comb begin
    pin_d = pin_q;
    if (restart) begin
      pin_d = init_d;
    end else if (cyc) begin
      if (match[sel]) begin
        for (int i = 0; i < NCMP; i++) begin
          if (!(i != int'(sel) && cmp_q[i] == cmp_q[sel])) pin_d[i] = init_q[i];
        end
      end else begin
        for (int i = 0; i < NCMP; i++) begin
          if (i != int'(sel) && match[i])
            pin_d[i] = apply_act(act_q[i*ACT_W +: 2], pin_q[i]);
        end
      end
    end else begin
      for (int p = 0; p < NCMP; p += 2) begin
        if (match[p] && match[p+1]) pin_d[p] = pin_q[p];
        else if (match[p])   pin_d[p] = apply_act(act_q[p*ACT_W +: 2], pin_q[p]);
        else if (match[p+1]) pin_d[p] = apply_act(act_q[(p+1)*ACT_W +: 2], pin_q[p]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  // R6: equal pair values leave the paired pin alone
  a_r6_pair_equal: assert property (@(posedge clk) disable iff (!rst_sn)
    (!restart && !cyc && match[0] && match[1]) |=> (pin_q[0] == $past(pin_q[0])));

  // R5: odd pins stay low whenever the channel is in paired mode
  a_r5_odd_low: assert property (@(posedge clk) disable iff (!rst_sn)
    !mode_d[M_CYC] |=> (!pin_q[1] && !pin_q[3]));

  // R8: period pin does not move between period matches
  a_r8_period_pin: assert property (@(posedge clk) disable iff (!rst_sn)
    (!restart && cyc && !match[sel]) |=> (pin_q[$past(sel)] == $past(pin_q[sel])));

  // R7: period match puts the period pin at its start level
  a_r7_period_init: assert property (@(posedge clk) disable iff (!rst_sn)
    (!restart && cyc && match[sel]) |=> (pin_q[$past(sel)] == $past(init_q[sel])));
endmodule

// File: rtl/cmpwm_channel.sv
module cmpwm_channel
  import cmpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NCMP-1:0]   pin_out,
  output logic [NCMP-1:0]   match_flag
);
  logic                       rst_sn;
  logic [NCMP-1:0]            match;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [ACT_BITS-1:0]        act_q, act_d;
  logic [MODE_W-1:0]          mode_q, mode_d;
  logic                       restart;

  cmpwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  cmpwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .enable(enable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .match(match), .cmp_q(cmp_q), .act_q(act_q), .act_d(act_d),
    .mode_q(mode_q), .mode_d(mode_d), .restart(restart), .flag_q(match_flag)
  );

  cmpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_sn(rst_sn), .enable(enable), .tick(tick),
    .restart(restart), .cyc_mode(mode_q[M_CYC]), .clr_en(mode_q[M_CLREN]),
    .sel(mode_q[M_SEL_LO +: IDX_W]), .cmp_q(cmp_q), .match(match)
  );

  cmpwm_pins #(.CNT_W(CNT_W)) u_pins (
    .clk(clk), .rst_sn(rst_sn), .restart(restart), .match(match),
    .cmp_q(cmp_q), .act_q(act_q), .act_d(act_d),
    .mode_q(mode_q), .mode_d(mode_d), .pin_q(pin_out)
  );
endmodule

// File: tb/sim_cmpwm_channel.sv
`timescale 1ns/1ps
module sim_cmpwm_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pin_out;
  logic [3:0]  match_flag;

  always #2 clk = ~clk;

  cmpwm_channel u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_out(pin_out), .match_flag(match_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the requirements
  logic [15:0] m_cnt;
  logic [15:0] m_cmp [4];
  logic [15:0] m_act;
  logic [3:0]  m_mode;
  logic [3:0]  m_pin;
  logic [3:0]  m_flag;

  function automatic logic [3:0] exp_start(input logic [3:0] md, input logic [15:0] ac);
    logic [3:0] r;
    r[0] = ac[2];
    r[2] = ac[10];
    r[1] = md[0] ? ac[6]  : 1'b0;
    r[3] = md[0] ? ac[14] : 1'b0;
    return r;
  endfunction

  function automatic logic do_act(input logic [1:0] c, input logic cur);
    if (c == 2'b01) return 1'b0;
    if (c == 2'b10) return 1'b1;
    if (c == 2'b11) return !cur;
    return cur;
  endfunction

  task automatic model_step(input logic en, input logic tk, input logic we,
                            input logic [2:0] wa, input logic [15:0] wd);
    logic [3:0]  mt, mode_n, pin_n, fclr;
    logic [15:0] act_n;
    logic        rs, clr;
    int          sl;
    for (int i = 0; i < 4; i++) mt[i] = en && tk && (m_cnt == m_cmp[i]);
    mode_n = (we && wa == 3'd5) ? wd[3:0] : m_mode;
    act_n  = (we && wa == 3'd4) ? (wd & 16'h7777) : m_act;
    fclr   = (we && wa == 3'd6) ? wd[3:0] : 4'h0;
    rs     = !en || (mode_n != m_mode);
    sl     = int'(m_mode[2:1]);
    clr    = mt[sl] && (m_mode[0] || m_mode[3]);
    pin_n  = m_pin;
    if (rs) pin_n = exp_start(mode_n, act_n);
    else if (m_mode[0]) begin
      if (mt[sl]) begin
        for (int i = 0; i < 4; i++)
          if (i == sl || m_cmp[i] != m_cmp[sl]) pin_n[i] = exp_start(m_mode, m_act)[i];
      end else begin
        for (int i = 0; i < 4; i++)
          if (i != sl && mt[i]) pin_n[i] = do_act(m_act[4*i +: 2], m_pin[i]);
      end
    end else begin
      for (int p = 0; p < 4; p += 2) begin
        if (m_cmp[p] != m_cmp[p+1]) begin
          if (mt[p])        pin_n[p] = do_act(m_act[4*p +: 2], m_pin[p]);
          else if (mt[p+1]) pin_n[p] = do_act(m_act[4*(p+1) +: 2], m_pin[p]);
        end
      end
    end
    if (rs)            m_cnt = '0;
    else if (en && tk) m_cnt = clr ? 16'd0 : m_cnt + 16'd1;
    if (we && wa < 3'd4) m_cmp[wa[1:0]] = wd;
    m_flag = (m_flag & ~fclr) | mt;
    m_act  = act_n;
    m_mode = mode_n;
    m_pin  = pin_n;
  endtask

  task automatic step(input logic en, input logic tk, input logic we,
                      input logic [2:0] wa, input logic [15:0] wd, input string tag);
    @(negedge clk);
    enable = en; tick = tk; wr_en = we; wr_addr = wa; wr_data = wd;
    model_step(en, tk, we, wa, wd);
    @(posedge clk);
    #1;
    n_chk++;
    if (pin_out !== m_pin) begin
      n_bad++;
      $display("FAIL %s pins got %b expected %b", tag, pin_out, m_pin);
    end
    n_chk++;
    if (match_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s flags got %b expected %b", tag, match_flag, m_flag);
    end
  endtask

  task automatic wr(input logic en, input logic [2:0] wa, input logic [15:0] wd,
                    input string tag);
    step(en, 1'b0, 1'b1, wa, wd, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = '0; m_act = '0; m_mode = '0; m_pin = '0; m_flag = '0;
    for (int i = 0; i < 4; i++) m_cmp[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle channel
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R1 reset");

    // R12 R5 R6: paired setup, pair 2/3 equal, clear on reg 1
    wr(1'b0, 3'd0, 16'd3, "R12 cmp0");
    wr(1'b0, 3'd1, 16'd8, "R12 cmp1");
    wr(1'b0, 3'd2, 16'd5, "R12 cmp2");
    wr(1'b0, 3'd3, 16'd5, "R12 cmp3");
    wr(1'b0, 3'd4, 16'hB3A5, "R4 actions");
    wr(1'b0, 3'd5, 16'h000A, "R10 mode paired");
    for (int k = 0; k < 30; k++)
      step(1'b1, (k % 5) != 4, 1'b0, 3'd0, 16'd0, "R2 R4 R5 R6 R11 paired");

    // R10: mode change while running, to period/duty with period = reg 3
    wr(1'b1, 3'd5, 16'h0007, "R10 mode change");
    wr(1'b1, 3'd3, 16'd10, "R12 period");
    wr(1'b1, 3'd0, 16'd4, "R12 duty0");
    wr(1'b1, 3'd1, 16'd10, "R9 duty equal");
    wr(1'b1, 3'd2, 16'd0, "R12 duty2");
    wr(1'b1, 3'd4, 16'h7352, "R4 actions");
    for (int k = 0; k < 40; k++)
      step(1'b1, 1'b1, 1'b0, 3'd0, 16'd0, "R7 R8 R9 R11 period");

    // R3: clear all flags, then clear again in a match cycle
    wr(1'b1, 3'd6, 16'h000F, "R3 flag clear");
    for (int k = 0; k < 12; k++)
      step(1'b1, 1'b1, 1'b1, 3'd6, 16'h000F, "R3 clear vs match");
    wr(1'b1, 3'd7, 16'hFFFF, "R12 unused addr");

    // R10: disable mid-run
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, 3'd0, 16'd0, "R10 disabled");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'b0, 3'd0, 16'd0, "R2 resume");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic        en, tk, we;
      logic [2:0]  wa;
      logic [15:0] wd;
      en = ($urandom % 32) != 0;
      tk = ($urandom % 4) != 0;
      we = ($urandom % 8) == 0;
      wa = 3'($urandom % 8);
      wd = 16'($urandom);
      if (wa < 3'd4) wd = 16'($urandom % 24);
      if (wa == 3'd5) begin
        if (($urandom % 4) != 0) wd[3] = 1'b1;
        if (($urandom % 3) != 0) wa = 3'd6;
      end
      step(en, tk, we, wa, wd, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end
    finish_run();
  end
endmodule